// File: doc/BRIEF.md
# Compare/PWM Timer Counter

An 8-bit up-counting timer that advances on a single-cycle count strobe while its 4-bit clock-select code is non-zero. The strobe comes from a prescaler outside the block. A small register port holds the control word, the count, two compare values (A and B), a sticky flag register and a mask register. Two interrupt lines come out of the block, and one waveform output.

The block has two modes. In normal mode, compare A can clear the counter and can toggle, clear or set the waveform output on a match. In PWM mode, compare B sets the last count of each period, and compare A sets the duty level. Compare A is double-buffered in PWM mode, so a duty change written at any time takes effect only at the next period boundary. This keeps every pulse a proper length. A match is raised only when the counter steps onto the compare value. Loading the counter or compare A to equal values raises nothing.

Top module: `tmr8_cmp_pwm`

## Requirements
- R1: After reset, every register reads 0, `wave_out` is 0 and both interrupt lines are 0.
- R2: When the clock-select code (control bits [3:0]) is 0000, the counter holds. Any other code advances it by one on each `cnt_tick`. In normal mode it wraps from 0xFF to 0x00.
- R3: A value written to the count register appears one clock after the write cycle. Such a write never produces a compare match, even when the value equals compare A.
- R4: In normal mode with clear-on-match (control bit 7) set, the counter reads 0x00 in the cycle after it holds the compare-A match value. With the bit clear, the counter keeps the match value and continues counting.
- R5: In normal mode, the output code (control bits [5:4]) acts in the cycle after a match: 00 forces `wave_out` to 0, 01 toggles it, 10 drives it low, 11 drives it high.
- R6: The compare flag (flag bit 1) sets in the cycle after a match. Writing 1 to that bit clears it. `irq_cmp` is high while both the flag and mask bit 1 are set.
- R7: The overflow flag (flag bit 0) sets on the step that wraps the counter, from 0xFF in normal mode or from the top value in PWM mode. It is cleared by writing 1 to it. `irq_ovf` follows the flag gated by mask bit 0.
- R8: In PWM mode (control bit 6), the counter runs 0x00 up to compare B, then returns to 0x00.
- R9: In PWM mode with code 10, `wave_out` is high for counts below compare A and low from the count equal to A up to the top. Code 11 gives the complement. Codes 00 and 01 hold `wave_out` at 0.
- R10: In PWM mode, compare A of 0x00 gives a constant low with code 10 (high with code 11). Compare A at or above the top gives a constant high with code 10 (low with code 11). A value of 0x00 takes precedence.
- R11: In PWM mode, a write to compare A goes to a buffer, and reads of compare A return that buffer. The buffer becomes the active duty on the step that wraps the counter from the top.
- R12: Register addresses: 0 control, 1 count, 2 compare A, 3 compare B, 4 flags, 5 mask. Addresses 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Single-cycle count strobe from the prescaler |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data for `reg_addr`, combinational |
| wave_out | output | 1 | Compare/PWM waveform output |
| irq_ovf | output | 1 | Overflow interrupt |
| irq_cmp | output | 1 | Compare-match interrupt |

## Verification
A wrong counter shows at the count register on the very next read, and in PWM mode it shows on `wave_out` within one period. A stale or early-committed duty value shows up as a pulse of the wrong length in the period where the buffered write lands. A match pulse that is lost or spurious shows in the cycle after the event, in three places: the compare flag, the cleared counter and the output action. A wrong wrap point shows as an overflow flag that is set too early or never set.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int unsigned AW = 3;

  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_CNT  = 3'd1;
  localparam logic [AW-1:0] A_CMPA = 3'd2;
  localparam logic [AW-1:0] A_CMPB = 3'd3;
  localparam logic [AW-1:0] A_FLAG = 3'd4;
  localparam logic [AW-1:0] A_MASK = 3'd5;

  localparam int unsigned FB_OVF = 0;
  localparam int unsigned FB_CMP = 1;

  typedef struct packed {
    logic       clr_on_match;
    logic       pwm_en;
    logic [1:0] omode;
    logic [3:0] csel;
  } ctrl_t;
endpackage

// File: rtl/tmr8_rst_sync.sv
module tmr8_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tmr8_regs.sv
module tmr8_regs
  import tmr8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  cnt_q,
  input  logic          ovf_evt,
  input  logic          match_pend,
  output ctrl_t         ctrl_q,
  output logic [W-1:0]  cmpa_act_q,
  output logic [W-1:0]  cmpa_act_d,
  output logic [W-1:0]  cmpa_buf_q,
  output logic [W-1:0]  cmpb_q,
  output logic          ld_pend_q,
  output logic [W-1:0]  ld_val_q,
  output logic [1:0]    flag_q,
  output logic [1:0]    mask_q,
  output logic [W-1:0]  rdata
);
  logic wr_ctrl, wr_cnt, wr_cmpa, wr_cmpb, wr_flag, wr_mask;
  ctrl_t        ctrl_d;
  logic [W-1:0] cmpa_buf_d, cmpb_d, ld_val_d;
  logic         ld_pend_d;
  logic [1:0]   flag_d, mask_d, clr_bits, set_bits;

  always_comb begin
    wr_ctrl = we && (addr == A_CTRL);
    wr_cnt  = we && (addr == A_CNT);
    wr_cmpa = we && (addr == A_CMPA);
    wr_cmpb = we && (addr == A_CMPB);
    wr_flag = we && (addr == A_FLAG);
    wr_mask = we && (addr == A_MASK);

    ctrl_d     = wr_ctrl ? ctrl_t'(wdata[7:0]) : ctrl_q;
    cmpb_d     = wr_cmpb ? wdata : cmpb_q;
    mask_d     = wr_mask ? wdata[1:0] : mask_q;
    cmpa_buf_d = wr_cmpa ? wdata : cmpa_buf_q;

    // Duty commit: follows the buffer outside PWM, only at the wrap inside it.
    if (!ctrl_q.pwm_en || ovf_evt) cmpa_act_d = cmpa_buf_q;
    else                           cmpa_act_d = cmpa_act_q;

    ld_pend_d = wr_cnt;
    ld_val_d  = wr_cnt ? wdata : ld_val_q;

    clr_bits = wr_flag ? wdata[1:0] : 2'b00;
    set_bits = '0;
    set_bits[FB_OVF] = ovf_evt;
    set_bits[FB_CMP] = match_pend;
    flag_d = (flag_q & ~clr_bits) | set_bits;

    case (addr)
      A_CTRL:  rdata = W'(ctrl_q);
      A_CNT:   rdata = cnt_q;
      A_CMPA:  rdata = cmpa_buf_q;
      A_CMPB:  rdata = cmpb_q;
      A_FLAG:  rdata = W'(flag_q);
      A_MASK:  rdata = W'(mask_q);
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      cmpa_act_q <= '0;
      cmpa_buf_q <= '0;
      cmpb_q     <= '0;
      ld_pend_q  <= 1'b0;
      ld_val_q   <= '0;
      flag_q     <= '0;
      mask_q     <= '0;
    end else begin
      ctrl_q     <= ctrl_d;
      cmpa_act_q <= cmpa_act_d;
      cmpa_buf_q <= cmpa_buf_d;
      cmpb_q     <= cmpb_d;
      ld_pend_q  <= ld_pend_d;
      ld_val_q   <= ld_val_d;
      flag_q     <= flag_d;
      mask_q     <= mask_d;
    end
  end
endmodule

// File: rtl/tmr8_core.sv
module tmr8_core #(
  parameter int unsigned W  = 8,
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] csel,
  input  logic          ctc_en,
  input  logic          pwm_en,
  input  logic [W-1:0]  top,
  input  logic [W-1:0]  cmpa_d,
  input  logic          ld_pend,
  input  logic [W-1:0]  ld_val,
  output logic [W-1:0]  cnt_q,
  output logic [W-1:0]  cnt_d,
  output logic          step,
  output logic          ovf_evt,
  output logic          match_pend_q
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic run, ctc_clr, at_top, match_d;

  always_comb begin
    run     = (csel != '0);
    ctc_clr = match_pend_q && ctc_en && !pwm_en && !ld_pend;
    step    = tick && run && !ld_pend && !ctc_clr;
    at_top  = pwm_en ? (cnt_q >= top) : (cnt_q == CNT_MAX);
    ovf_evt = step && at_top;

    if (ld_pend)      cnt_d = ld_val;
    else if (ctc_clr) cnt_d = '0;
    else if (step)    cnt_d = at_top ? '0 : cnt_q + W'(1);
    else              cnt_d = cnt_q;

    // Only a real count step can land on the compare value.
    match_d = step && (cnt_d == cmpa_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q        <= '0;
      match_pend_q <= 1'b0;
    end else begin
      cnt_q        <= cnt_d;
      match_pend_q <= match_d;
    end
  end
endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwm_en,
  input  logic [1:0]   omode,
  input  logic [W-1:0] cnt_d,
  input  logic [W-1:0] cmpa_d,
  input  logic [W-1:0] top,
  input  logic         match_pend,
  output logic         wave_out
);
  logic out_q, out_d, lvl, drive;

  always_comb begin
    if (cmpa_d == '0)       lvl = 1'b0;
    else if (cmpa_d >= top) lvl = 1'b1;
    else                    lvl = (cnt_d < cmpa_d);

    out_d = out_q;
    if (pwm_en) begin
      out_d = lvl ^ omode[0];
    end else if (match_pend) begin
      case (omode)
        2'b01:   out_d = ~out_q;
        2'b10:   out_d = 1'b0;
        2'b11:   out_d = 1'b1;
        default: out_d = out_q;
      endcase
    end

    drive = pwm_en ? omode[1] : (omode != 2'b00);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign wave_out = drive & out_q;
endmodule

// File: rtl/tmr8_cmp_pwm.sv
module tmr8_cmp_pwm
  import tmr8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_tick,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  output logic          wave_out,
  output logic          irq_ovf,
  output logic          irq_cmp
);
  localparam int unsigned CW = $bits(ctrl_t) - 4;

  logic         rst_sync_n;
  ctrl_t        ctrl_q;
  logic [W-1:0] cmpa_act_q, cmpa_act_d, cmpa_buf_q, cmpb_q, ld_val_q;
  logic [W-1:0] cnt_q, cnt_d;
  logic         ld_pend_q, step, ovf_evt, match_pend_q;
  logic [1:0]   flag_q, mask_q;

  tmr8_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tmr8_regs #(.W(W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .we         (reg_we),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .cnt_q      (cnt_q),
    .ovf_evt    (ovf_evt),
    .match_pend (match_pend_q),
    .ctrl_q     (ctrl_q),
    .cmpa_act_q (cmpa_act_q),
    .cmpa_act_d (cmpa_act_d),
    .cmpa_buf_q (cmpa_buf_q),
    .cmpb_q     (cmpb_q),
    .ld_pend_q  (ld_pend_q),
    .ld_val_q   (ld_val_q),
    .flag_q     (flag_q),
    .mask_q     (mask_q),
    .rdata      (reg_rdata)
  );

  tmr8_core #(.W(W), .CW(CW)) u_core (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .tick         (cnt_tick),
    .csel         (ctrl_q.csel),
    .ctc_en       (ctrl_q.clr_on_match),
    .pwm_en       (ctrl_q.pwm_en),
    .top          (cmpb_q),
    .cmpa_d       (cmpa_act_d),
    .ld_pend      (ld_pend_q),
    .ld_val       (ld_val_q),
    .cnt_q        (cnt_q),
    .cnt_d        (cnt_d),
    .step         (step),
    .ovf_evt      (ovf_evt),
    .match_pend_q (match_pend_q)
  );

  tmr8_wave #(.W(W)) u_wave (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .pwm_en     (ctrl_q.pwm_en),
    .omode      (ctrl_q.omode),
    .cnt_d      (cnt_d),
    .cmpa_d     (cmpa_act_d),
    .top        (cmpb_q),
    .match_pend (match_pend_q),
    .wave_out   (wave_out)
  );

  assign irq_ovf = flag_q[FB_OVF] & mask_q[FB_OVF];
  assign irq_cmp = flag_q[FB_CMP] & mask_q[FB_CMP];
endmodule

// File: rtl/tmr8_chk.sv
module tmr8_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [7:0]   ctrl,
  input logic [W-1:0] cnt,
  input logic         ld_pend,
  input logic [W-1:0] ld_val,
  input logic         match_pend,
  input logic         step,
  input logic [W-1:0] cmpb,
  input logic [W-1:0] cmpa_act,
  input logic [W-1:0] cmpa_buf,
  input logic [1:0]   flag,
  input logic         wave_out
);
  p_stop_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[3:0] == 4'd0 && !ld_pend && !(match_pend && ctrl[7] && !ctrl[6]))
      |=> cnt == $past(cnt));

  p_load_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pend |=> cnt == $past(ld_val));

  p_ctc_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_pend && ctrl[7] && !ctrl[6] && !ld_pend) |=> cnt == '0);

  p_cmp_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    match_pend |=> flag[1]);

  p_pwm_wrap_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[6] && step && cnt >= cmpb) |=> flag[0]);

  p_pwm_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[6] && ctrl[5:4] == 2'b10 && cmpa_act == '0 && cmpa_buf == '0)
      |=> !wave_out);

  p_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[6] && step && cnt >= cmpb) |=> cmpa_act == $past(cmpa_buf));
endmodule

bind tmr8_cmp_pwm tmr8_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .ctrl       (ctrl_q),
  .cnt        (cnt_q),
  .ld_pend    (ld_pend_q),
  .ld_val     (ld_val_q),
  .match_pend (match_pend_q),
  .step       (step),
  .cmpb       (cmpb_q),
  .cmpa_act   (cmpa_act_q),
  .cmpa_buf   (cmpa_buf_q),
  .flag       (flag_q),
  .wave_out   (wave_out)
);

// File: tb/tb_tmr8_cmp_pwm.sv
`timescale 1ns/1ps
module tb_tmr8_cmp_pwm;
  localparam int W = 8;
  localparam logic [2:0] AC = 3'd0, AN = 3'd1, AA = 3'd2, AB = 3'd3,
                         AF = 3'd4, AM = 3'd5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic         we = 1'b0;
  logic [2:0]   addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         wave_out, irq_ovf, irq_cmp;

  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr8_cmp_pwm #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_tick(tick), .reg_we(we),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
    .wave_out(wave_out), .irq_ovf(irq_ovf), .irq_cmp(irq_cmp)
  );

  function automatic logic [7:0] mk(input logic ctc, input logic pwm,
                                    input logic [1:0] om, input logic [3:0] cs);
    return {ctc, pwm, om, cs};
  endfunction

  function automatic logic pexp(input int c, input int duty, input int top,
                                input logic inv);
    logic lvl;
    if (duty == 0)        lvl = 1'b0;
    else if (duty >= top) lvl = 1'b1;
    else                  lvl = (c < duty);
    return lvl ^ inv;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    cyc();
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    addr = a;
    #0.5;
    d = int'(rdata);
  endtask

  task automatic pulse();
    tick = 1'b1;
    cyc();
    tick = 1'b0;
  endtask

  // counter is loaded with v-1, steps onto v; returns one cycle after the match
  task automatic hit_match(input int v);
    wr(AN, 8'(v - 1));
    cyc();
    pulse();
    cyc();
  endtask

  // checks one full PWM period: sequence 0..top and the pin level per count
  task automatic run_period(input int top, input int duty, input logic inv, input string tag);
    int c, prev;
    rd(AN, prev);
    for (int i = 0; i <= top; i++) begin
      pulse();
      rd(AN, c);
      chk("R8 counter sequence", c, (prev >= top) ? 0 : prev + 1);
      chk(tag, int'(wave_out), int'(pexp(c, duty, top, inv)));
      prev = c;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      nvec++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int v, cnt_exp, n;
    void'($urandom(32'h5eed_0017));
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();

    // R1 reset state, R12 unused address
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 reset register", v, 0);
    end
    chk("R1 reset wave_out", int'(wave_out), 0);
    chk("R1 reset irq_ovf", int'(irq_ovf), 0);
    chk("R1 reset irq_cmp", int'(irq_cmp), 0);
    rd(3'd6, v);
    chk("R12 unused address reads 0", v, 0);

    // R2 stopped, then running
    repeat (5) pulse();
    rd(AN, v);
    chk("R2 stopped counter holds", v, 0);
    wr(AC, mk(0, 0, 2'b00, 4'd1));
    repeat (5) pulse();
    rd(AN, v);
    chk("R2 running counter advances", v, 5);
    rd(AC, v);
    chk("R12 control readback", v, 8'h01);

    // R3 delayed load, no match from write
    wr(AA, 8'h50);
    wr(AF, 8'h03);
    wr(AN, 8'h50);
    rd(AN, v);
    chk("R3 load not yet visible", v, 5);
    cyc();
    rd(AN, v);
    chk("R3 load visible after one cycle", v, 8'h50);
    cyc(); cyc();
    rd(AF, v);
    chk("R3 write creates no match", v & 2, 0);

    // R6 flag timing, mask, write-one-clear; R4 no clear with bit off
    wr(AN, 8'h4F);
    cyc();
    pulse();
    rd(AF, v);
    chk("R6 flag not set in match cycle", v & 2, 0);
    cyc();
    rd(AF, v);
    chk("R6 flag set cycle after match", v & 2, 2);
    chk("R6 irq masked", int'(irq_cmp), 0);
    rd(AN, v);
    chk("R4 no clear when bit off", v, 8'h50);
    pulse();
    rd(AN, v);
    chk("R4 keeps counting", v, 8'h51);
    wr(AM, 8'h02);
    chk("R6 irq when unmasked", int'(irq_cmp), 1);
    wr(AF, 8'h02);
    rd(AF, v);
    chk("R6 write one clears flag", v & 2, 0);
    chk("R6 irq drops", int'(irq_cmp), 0);

    // R4 clear on match
    wr(AC, mk(1, 0, 2'b00, 4'd1));
    wr(AN, 8'h4F);
    cyc();
    pulse();
    rd(AN, v);
    chk("R4 holds match value one cycle", v, 8'h50);
    cyc();
    rd(AN, v);
    chk("R4 cleared after match", v, 0);

    // R5 normal output modes
    wr(AA, 8'h30);
    wr(AC, mk(0, 0, 2'b01, 4'd1));
    hit_match(8'h30);
    chk("R5 toggle to high", int'(wave_out), 1);
    hit_match(8'h30);
    chk("R5 toggle to low", int'(wave_out), 0);
    wr(AC, mk(0, 0, 2'b11, 4'd1));
    hit_match(8'h30);
    chk("R5 set on match", int'(wave_out), 1);
    wr(AC, mk(0, 0, 2'b00, 4'd1));
    cyc();
    chk("R5 disconnected reads 0", int'(wave_out), 0);
    wr(AC, mk(0, 0, 2'b10, 4'd1));
    cyc();
    chk("R5 level retained while disconnected", int'(wave_out), 1);
    hit_match(8'h30);
    chk("R5 clear on match", int'(wave_out), 0);

    // R7 normal overflow
    wr(AC, mk(0, 0, 2'b00, 4'd1));
    wr(AF, 8'h03);
    wr(AM, 8'h01);
    wr(AN, 8'hFE);
    cyc();
    pulse();
    rd(AF, v);
    chk("R7 no overflow at 0xFF", v & 1, 0);
    pulse();
    rd(AN, v);
    chk("R2 wraps to 0", v, 0);
    rd(AF, v);
    chk("R7 overflow on wrap", v & 1, 1);
    chk("R7 irq_ovf", int'(irq_ovf), 1);
    wr(AF, 8'h01);
    chk("R7 irq_ovf cleared", int'(irq_ovf), 0);

    // R9 R11 R8 PWM directed: top 9, duty 4, then buffered change to 7
    wr(AB, 8'd9);
    wr(AA, 8'd4);
    cyc();
    wr(AC, mk(0, 1, 2'b10, 4'd1));
    wr(AN, 8'd0);
    cyc();
    chk("R9 high at count 0", int'(wave_out), 1);
    run_period(9, 4, 1'b0, "R9 non-inverted level");
    pulse(); pulse();
    wr(AA, 8'd7);
    rd(AA, v);
    chk("R11 read returns buffered value", v, 7);
    wr(AF, 8'h03);
    repeat (3) pulse();
    rd(AN, v);
    chk("R11 counter at 5", v, 5);
    chk("R11 old duty still active", int'(wave_out), 0);
    repeat (4) pulse();
    rd(AF, v);
    chk("R7 no overflow before top wrap", v & 1, 0);
    pulse();
    rd(AN, v);
    chk("R8 wraps from top", v, 0);
    rd(AF, v);
    chk("R7 overflow at top wrap", v & 1, 1);
    repeat (5) pulse();
    chk("R11 new duty after wrap", int'(wave_out), 1);
    run_period(9, 7, 1'b0, "R11 committed duty level");

    // R10 constant levels
    wr(AA, 8'd0);
    repeat (11) pulse();
    run_period(9, 0, 1'b0, "R10 duty 0 held low");
    wr(AC, mk(0, 1, 2'b11, 4'd1));
    run_period(9, 0, 1'b1, "R10 inverted duty 0 held high");
    wr(AA, 8'd9);
    repeat (11) pulse();
    run_period(9, 9, 1'b1, "R10 inverted duty top held low");
    wr(AC, mk(0, 1, 2'b10, 4'd1));
    run_period(9, 9, 1'b0, "R10 duty top held high");

    // R9 disconnected codes in PWM
    wr(AA, 8'd4);
    repeat (11) pulse();
    wr(AC, mk(0, 1, 2'b01, 4'd1));
    for (int i = 0; i < 10; i++) begin
      pulse();
      chk("R9 code 01 disconnected", int'(wave_out), 0);
    end

    // random PWM periods
    for (int it = 0; it < 14; it++) begin
      int top, duty;
      logic inv;
      top  = $urandom_range(2, 30);
      duty = $urandom_range(0, top);
      inv  = 1'($urandom_range(0, 1));
      wr(AB, 8'(top));
      wr(AC, mk(0, 1, {1'b1, inv}, 4'($urandom_range(1, 15))));
      wr(AA, 8'(duty));
      wr(AN, 8'd0);
      cyc();
      repeat (top + 2) pulse();
      run_period(top, duty, inv, "R9 random PWM level");
    end

    // random normal-mode strobe patterns
    for (int it = 0; it < 10; it++) begin
      int r0, ticks;
      wr(AC, mk(0, 0, 2'b00, 4'($urandom_range(1, 15))));
      wr(AF, 8'h03);
      r0 = $urandom_range(0, 255);
      wr(AN, 8'(r0));
      cyc();
      n = $urandom_range(20, 300);
      ticks = 0;
      for (int k = 0; k < n; k++) begin
        tick = 1'($urandom_range(0, 1));
        if (tick) ticks++;
        cyc();
      end
      tick = 1'b0;
      cnt_exp = (r0 + ticks) % 256;
      rd(AN, v);
      chk("R2 random strobe count", v, cnt_exp);
      rd(AF, v);
      chk("R7 random overflow", v & 1, (r0 + ticks >= 256) ? 1 : 0);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule